// File: doc/BRIEF.md
# I2C Register Port with Pointer

This block is an I2C target that exposes a small bank of byte registers to a bus master. A system clock oversamples the open-drain SCL and SDA lines. The lines arrive as plain inputs, and the block pulls SDA low through a single output-enable. After a START, the block compares the first byte against its 7-bit device address. One bit of that address comes from a strap pin, so two instances can share a bus.

In a write transaction, the byte after the address loads an internal pointer. Every later byte is stored into the register that the pointer selects. In a read transaction, the block sends the register selected by the pointer that is already held. It keeps sending while the master acknowledges each byte.

The top bit of the pointer byte turns on auto-increment. When it is on, the pointer steps after each data byte inside one of two register sections, 01h–08h and 09h–11h. It never passes from the first section into the second, and it stops on the last register of a section.

Top module: `i2c_ptr_regport`

## Requirements
- R1: The device address is binary 001100 in its upper six bits, followed by the level of `addr_sel_i`. With `addr_sel_i`=0 the address bytes are 30h (write) and 31h (read); with `addr_sel_i`=1 they are 32h (write) and 33h (read).
- R2: Bit 0 of the address byte selects the direction: 0 is a write and 1 is a read.
- R3: In a write transaction, the first byte after the address byte becomes the pointer (bit 7 is the increment flag, bits 6:0 the register number). Each following byte is stored into the register that the pointer selects.
- R4: When the pointer's bit 7 is 0, the pointer does not change across data bytes, so successive bytes overwrite the same register.
- R5: When the pointer's bit 7 is 1, the pointer advances by one after each data byte written or read, inside 01h–08h and inside 09h–11h. It never moves from 08h to 09h.
- R6: With the increment flag set, a pointer at 08h or 11h stays there, so further bytes hit that last register again.
- R7: In a matched transaction, the block holds SDA low during the ninth clock of every byte it receives: address, pointer and data.
- R8: On an address mismatch, the block does not acknowledge and ignores all bytes until the next START or STOP. No register changes.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both after two-flop synchronization. A STOP releases SDA. A repeated START restarts address matching and keeps the pointer.
- R10: A write to a pointer outside 01h–11h is acknowledged and discarded. A read from such a pointer returns 00h.
- R11: After reset, all registers read 00h, SDA is released and the pointer is 00h with increment off.
- R12: The block changes its SDA drive only while the synchronized SCL is low. The only exception is the release caused by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| addr_sel_i | input | 1 | Strap that sets the lowest device-address bit |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench's main target is the two section boundaries. It writes and reads past 08h and 11h with increment on and checks that 09h stays untouched. A design that wrapped or crossed sections would show the overflow byte in 09h, or in 01h or 09h, and would read back a shifted sequence. The bench also writes the same pointer several times with increment off, which exposes any unconditional stepping. Writes and reads at pointers 00h and 12h catch a design that aliases out-of-range numbers onto real registers. A transaction to a foreign address carries bytes that look like a valid pointer and data, so a design that keeps decoding after a mismatch would both acknowledge and corrupt a register. Changing the strap and repeating the writes catches an address compare that ignores the pin.

// File: rtl/i2c_rp_pkg.sv
// Shared types for the I2C register port.
// Assumes a byte-wide bus protocol; nothing here is parameter dependent.
package i2c_rp_pkg;

    localparam int BYTE_W = 8;

    // Bus-level phase of the target state machine.
    typedef enum logic [2:0] {
        ST_IDLE,   // released, waiting for START
        ST_RECV,   // shifting in a byte from the master
        ST_RACK,   // driving our acknowledge bit
        ST_SEND,   // shifting out a read byte
        ST_MACK    // sampling the master's acknowledge
    } rp_state_e;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } rp_kind_e;

endpackage

// File: rtl/i2c_rp_sync.sv
// Two-line synchronizer and bus-event detector.
// Brings SCL and SDA into the clk domain through STAGES flops each, then
// flags SCL edges and START/STOP conditions from consecutive samples.
// Assumes clk is several times faster than SCL.
module i2c_rp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        // Metastability chain for one bus line; idles high like the bus.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign cur[g] = pipe[STAGES-1];
    end

    // Previous synchronized sample, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= cur;
    end

    assign scl_s     = cur[1];
    assign sda_s     = cur[0];
    assign scl_rise  = cur[1] & ~prev[1];
    assign scl_fall  = ~cur[1] & prev[1];
    assign start_det = cur[1] & prev[1] & prev[0] & ~cur[0];
    assign stop_det  = cur[1] & prev[1] & ~prev[0] & cur[0];

endmodule

// File: rtl/i2c_rp_core.sv
// Byte-level I2C target state machine.
// Receives address/pointer/data bytes, drives acknowledges, shifts out read
// data and issues one-cycle strobes to the register file. Assumes no clock
// stretching; all SDA changes are made after a detected SCL fall.
module i2c_rp_core
    import i2c_rp_pkg::*;
#(
    parameter logic [5:0] DEV_HI = 6'b001100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr_sel_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              ptr_ld_o,
    output logic              wr_en_o,
    output logic              rd_adv_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              sda_oe_o,
    output logic              idle_o
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    rp_state_e         state;
    rp_kind_e          kind;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw;
    logic              nack;

    // Protocol sequencing: events, byte assembly, acknowledge and read shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind     <= K_ADDR;
            bitcnt   <= '0;
            shreg    <= '0;
            rw       <= 1'b0;
            nack     <= 1'b0;
            sda_oe_o <= 1'b0;
            ptr_ld_o <= 1'b0;
            wr_en_o  <= 1'b0;
            rd_adv_o <= 1'b0;
        end else begin
            ptr_ld_o <= 1'b0;
            wr_en_o  <= 1'b0;
            rd_adv_o <= 1'b0;
            if (start_det) begin
                state    <= ST_RECV;
                kind     <= K_ADDR;
                bitcnt   <= '0;
                sda_oe_o <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (state)
                    ST_RECV: begin
                        if (scl_rise && bitcnt != FULL) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == FULL) begin
                            case (kind)
                                K_ADDR: begin
                                    if (shreg[7:1] == {DEV_HI, addr_sel_i}) begin
                                        rw       <= shreg[0];
                                        sda_oe_o <= 1'b1;
                                        state    <= ST_RACK;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                K_PTR: begin
                                    ptr_ld_o <= 1'b1;
                                    sda_oe_o <= 1'b1;
                                    state    <= ST_RACK;
                                end
                                default: begin
                                    wr_en_o  <= 1'b1;
                                    sda_oe_o <= 1'b1;
                                    state    <= ST_RACK;
                                end
                            endcase
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (kind == K_ADDR && rw) begin
                                state    <= ST_SEND;
                                shreg    <= rd_data_i;
                                sda_oe_o <= ~rd_data_i[BYTE_W-1];
                            end else begin
                                state    <= ST_RECV;
                                sda_oe_o <= 1'b0;
                                kind     <= (kind == K_ADDR) ? K_PTR : K_DATA;
                            end
                        end
                    end
                    ST_SEND: begin
                        if (scl_fall) begin
                            if (bitcnt == LAST) begin
                                sda_oe_o <= 1'b0;
                                rd_adv_o <= 1'b1;
                                state    <= ST_MACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe_o <= ~shreg[BYTE_W-2];
                                bitcnt   <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            nack <= sda_s;
                        end else if (scl_fall) begin
                            if (nack) begin
                                state <= ST_IDLE;
                            end else begin
                                state    <= ST_SEND;
                                bitcnt   <= '0;
                                shreg    <= rd_data_i;
                                sda_oe_o <= ~rd_data_i[BYTE_W-1];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign byte_o = shreg;
    assign idle_o = (state == ST_IDLE);

endmodule

// File: rtl/i2c_rp_regfile.sv
// Register bank and sectioned address pointer.
// Registers SEC1_LO..SEC2_HI are stored; SEC1_HI+1 must equal SEC2_LO.
// Pointer bit 7 enables stepping, which stays inside a section and holds at
// its last register. Out-of-range writes are dropped and reads return zero.
module i2c_rp_regfile
    import i2c_rp_pkg::*;
#(
    parameter int SEC1_LO = 1,
    parameter int SEC1_HI = 8,
    parameter int SEC2_LO = 9,
    parameter int SEC2_HI = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_ld_i,
    input  logic              wr_en_i,
    input  logic              adv_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [BYTE_W-1:0] ptr_o,
    output logic [BYTE_W-1:0] rd_data_o
);

    localparam int AW = BYTE_W - 1;
    localparam logic [AW-1:0] L1 = AW'(SEC1_LO);
    localparam logic [AW-1:0] H1 = AW'(SEC1_HI);
    localparam logic [AW-1:0] L2 = AW'(SEC2_LO);
    localparam logic [AW-1:0] H2 = AW'(SEC2_HI);

    logic [BYTE_W-1:0] regs [SEC1_LO:SEC2_HI];
    logic [BYTE_W-1:0] ptr_q;
    logic [AW-1:0]     addr;
    logic [AW-1:0]     addr_nx;
    logic              stepable;

    assign addr     = ptr_q[AW-1:0];
    assign stepable = ((addr >= L1) && (addr < H1)) || ((addr >= L2) && (addr < H2));
    assign addr_nx  = (ptr_q[BYTE_W-1] && stepable) ? addr + 1'b1 : addr;

    // Pointer load from the bus, or step after a data byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr_q <= '0;
        else if (ptr_ld_i) ptr_q <= byte_i;
        else if (adv_i)    ptr_q <= {ptr_q[BYTE_W-1], addr_nx};
    end

    // Register storage: write the addressed register when it exists.
    always_ff @(posedge clk) begin
        for (int i = SEC1_LO; i <= SEC2_HI; i++) begin
            if (!rst_n)                                regs[i] <= '0;
            else if (wr_en_i && addr == AW'(i))        regs[i] <= byte_i;
        end
    end

    // Read mux: zero unless the pointer names a stored register.
    always_comb begin
        rd_data_o = '0;
        for (int i = SEC1_LO; i <= SEC2_HI; i++) begin
            if (addr == AW'(i)) rd_data_o = regs[i];
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/i2c_ptr_regport.sv
// Top level of the I2C register port.
// Wires the line synchronizer, the byte state machine and the pointer-based
// register bank. SDA is open-drain: sda_oe_o high means pull the line low.
module i2c_ptr_regport
    import i2c_rp_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] DEV_HI      = 6'b001100,
    parameter int         SEC1_LO     = 1,
    parameter int         SEC1_HI     = 8,
    parameter int         SEC2_LO     = 9,
    parameter int         SEC2_HI     = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_sel_i,
    output logic sda_oe_o
);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              ptr_ld, wr_en, rd_adv, ptr_step, core_idle;
    logic [BYTE_W-1:0] bus_byte, rd_data, ptr_q;

    assign ptr_step = wr_en | rd_adv;

    i2c_rp_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rp_core #(.DEV_HI(DEV_HI)) core_i (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .addr_sel_i(addr_sel_i),
        .rd_data_i(rd_data), .ptr_ld_o(ptr_ld), .wr_en_o(wr_en),
        .rd_adv_o(rd_adv), .byte_o(bus_byte), .sda_oe_o(sda_oe_o),
        .idle_o(core_idle)
    );

    i2c_rp_regfile #(
        .SEC1_LO(SEC1_LO), .SEC1_HI(SEC1_HI), .SEC2_LO(SEC2_LO), .SEC2_HI(SEC2_HI)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .ptr_ld_i(ptr_ld), .wr_en_i(wr_en),
        .adv_i(ptr_step), .byte_i(bus_byte), .ptr_o(ptr_q), .rd_data_o(rd_data)
    );

endmodule

// File: rtl/i2c_rp_chk.sv
// Protocol and pointer checker for the I2C register port, bound to the top.
// Observes the synchronized bus events, the SDA drive and the pointer.
module i2c_rp_chk #(
    parameter int SEC1_HI = 8,
    parameter int SEC2_LO = 9,
    parameter int SEC2_HI = 17
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe_o,
    input logic       core_idle,
    input logic       ptr_step,
    input logic [7:0] ptr_q
);

    localparam logic [6:0] H1 = 7'(SEC1_HI);
    localparam logic [6:0] L2 = 7'(SEC2_LO);
    localparam logic [6:0] H2 = 7'(SEC2_HI);

    // R9: a STOP always leaves SDA released.
    a_r9_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    // R12: drive changes only with SCL low, apart from START/STOP release.
    a_r12_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

    // R8: an idle target never pulls SDA.
    a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        core_idle |-> !sda_oe_o);

    // R4: without the increment flag a data byte leaves the pointer alone.
    a_r4_ptr_static: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_step && !ptr_q[7]) |=> $stable(ptr_q));

    // R5: stepping from the first section's end never reaches the second.
    a_r5_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_step && ptr_q[6:0] == H1) |=> ptr_q[6:0] != L2);

    // R6: stepping at the last register of the second section holds there.
    a_r6_hold_sec2: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_step && ptr_q[6:0] == H2) |=> ptr_q[6:0] == H2);

    // R6: stepping at the last register of the first section holds there.
    a_r6_hold_sec1: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_step && ptr_q[6:0] == H1) |=> ptr_q[6:0] == H1);

endmodule

bind i2c_ptr_regport i2c_rp_chk #(
    .SEC1_HI(SEC1_HI), .SEC2_LO(SEC2_LO), .SEC2_HI(SEC2_HI)
) chk_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .sda_oe_o(sda_oe_o), .core_idle(core_idle),
    .ptr_step(ptr_step), .ptr_q(ptr_q)
);

// File: tb/i2c_ptr_regport_tb.sv
// Directed bench for the I2C register port: one task per scenario.
module i2c_ptr_regport_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sel = 1'b0;
    logic sda_oe_o;
    logic sda_line;
    int   vectors = 0;
    int   miscompares = 0;

    always #2 clk = ~clk;   // 250 MHz

    assign sda_line = sda_m & ~sda_oe_o;

    i2c_ptr_regport dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel_i(sel), .sda_oe_o(sda_oe_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(5);
        scl_m = 1'b1; tick(10);
        sda_m = 1'b0; tick(10);
        scl_m = 1'b0; tick(5);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(5);
        scl_m = 1'b1; tick(10);
        sda_m = 1'b1; tick(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(5);
            scl_m = 1'b1; tick(10);
            scl_m = 1'b0; tick(5);
        end
        sda_m = 1'b1; tick(5);
        scl_m = 1'b1; tick(5);
        ack = ~sda_line; tick(5);
        scl_m = 1'b0; tick(5);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(5);
            scl_m = 1'b1; tick(5);
            b[i] = sda_line; tick(5);
            scl_m = 1'b0;
        end
        tick(5);
        sda_m = ~mack;
        scl_m = 1'b1; tick(10);
        scl_m = 1'b0; tick(5);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic rd);
        return {6'b001100, sel, rd};
    endfunction

    // Write n bytes (MSB-first in d) after a pointer byte; every ACK checked (R7).
    task automatic wr_txn(input logic [7:0] ptr, input int n, input logic [31:0] d);
        logic ack;
        bus_start;
        send_byte(dev(1'b0), ack); chk("R7 address ack", 32'(ack), 32'd1);
        send_byte(ptr, ack);       chk("R7 pointer ack", 32'(ack), 32'd1);
        for (int i = n - 1; i >= 0; i--) begin
            send_byte(d[8*i +: 8], ack); chk("R7 data ack", 32'(ack), 32'd1);
        end
        bus_stop;
    endtask

    // Set pointer, repeated START, read n bytes (R2, R9).
    task automatic rd_txn(input logic [7:0] ptr, input int n, output logic [31:0] got);
        logic ack;
        logic [7:0] b;
        got = '0;
        bus_start;
        send_byte(dev(1'b0), ack);
        send_byte(ptr, ack);
        bus_start;
        send_byte(dev(1'b1), ack); chk("R2 read address ack", 32'(ack), 32'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            got = {got[23:0], b};
        end
        bus_stop;
    endtask

    task automatic t_reset;
        logic [31:0] g;
        chk("R11 sda released after reset", 32'(sda_oe_o), 32'd0);
        rd_txn(8'h01, 1, g); chk("R11 reg 01h reset value", g, 32'h00);
        rd_txn(8'h11, 1, g); chk("R11 reg 11h reset value", g, 32'h00);
    endtask

    task automatic t_single;
        logic [31:0] g;
        wr_txn(8'h03, 1, 32'hA5);
        rd_txn(8'h03, 1, g); chk("R3 pointer then data", g, 32'hA5);
    endtask

    task automatic t_no_incr;
        logic [31:0] g;
        wr_txn(8'h05, 3, 32'h112233);
        rd_txn(8'h05, 1, g); chk("R4 last byte kept", g, 32'h33);
        rd_txn(8'h06, 1, g); chk("R4 neighbour untouched", g, 32'h00);
        rd_txn(8'h05, 2, g); chk("R4 read repeats register", g, 32'h3333);
    endtask

    task automatic t_sec1;
        logic [31:0] g;
        wr_txn(8'h86, 4, 32'h01020304);
        rd_txn(8'h86, 3, g); chk("R5 R6 section one burst", g, 32'h010204);
        rd_txn(8'h09, 1, g); chk("R5 no cross into 09h", g, 32'h00);
    endtask

    task automatic t_sec2;
        logic [31:0] g;
        wr_txn(8'h8F, 4, 32'h05060708);
        rd_txn(8'h8F, 4, g); chk("R6 section two hold at 11h", g, 32'h05060808);
        rd_txn(8'h01, 1, g); chk("R6 no wrap to 01h", g, 32'h00);
    endtask

    task automatic t_range;
        logic [31:0] g;
        wr_txn(8'h00, 1, 32'hFF);
        wr_txn(8'h12, 1, 32'hEE);
        rd_txn(8'h00, 1, g); chk("R10 read 00h", g, 32'h00);
        rd_txn(8'h12, 1, g); chk("R10 read 12h", g, 32'h00);
        rd_txn(8'h01, 1, g); chk("R10 no alias to 01h", g, 32'h00);
    endtask

    task automatic t_mismatch;
        logic ack;
        logic [31:0] g;
        bus_start;
        send_byte(8'h34, ack); chk("R8 foreign address nack", 32'(ack), 32'd0);
        send_byte(8'h03, ack); chk("R8 ignored byte nack", 32'(ack), 32'd0);
        send_byte(8'h77, ack); chk("R8 ignored byte nack", 32'(ack), 32'd0);
        bus_stop;
        rd_txn(8'h03, 1, g); chk("R8 register unchanged", g, 32'hA5);
    endtask

    task automatic t_strap;
        logic ack;
        logic [31:0] g;
        sel = 1'b1; tick(4);
        wr_txn(8'h02, 1, 32'h3C);
        rd_txn(8'h02, 1, g); chk("R1 strap high address", g, 32'h3C);
        bus_start;
        send_byte(8'h30, ack); chk("R1 strap-low address refused", 32'(ack), 32'd0);
        bus_stop;
        sel = 1'b0; tick(4);
    endtask

    task automatic t_restart;
        logic ack;
        logic [7:0] b;
        bus_start;
        send_byte(8'h30, ack);
        send_byte(8'h83, ack);
        bus_start;
        send_byte(8'h31, ack); chk("R9 repeated start rematch", 32'(ack), 32'd1);
        recv_byte(1'b1, b);    chk("R9 pointer kept 03h", 32'(b), 32'hA5);
        recv_byte(1'b0, b);    chk("R5 read step to 04h", 32'(b), 32'h00);
        bus_stop;
        chk("R9 released after stop", 32'(sda_oe_o), 32'd0);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(20);
        t_reset;
        t_single;
        t_no_incr;
        t_sec1;
        t_sec2;
        t_range;
        t_mismatch;
        t_strap;
        t_restart;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        tick(150000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule